// File: doc/BRIEF.md
# Phase-Offset Programmable Clock Divider

This block divides a fast clock by an integer ratio built from two programmable segment lengths: a high segment and a low segment. A synchronisation pulse restarts the divider. After the pulse ends, the divider holds a programmed starting level for a programmed number of fast-clock edges. It then makes its first transition and runs freely. Several copies that share one pulse but have different offsets therefore have output edges skewed by whole fast-clock periods.

All configuration is captured while the pulse is high, so changes applied while the divider runs have no effect until the next pulse. A bypass setting routes the fast clock straight to the output. In bypass, the offset and starting level have no effect.

Top module: `phase_clk_div`

## Requirements
- R1: `hi_len` and `lo_len` hold the segment length minus one (0 means 1 cycle, 15 means 16 cycles), so the divide ratio N is `hi_len + lo_len + 2`.
- R2: At every fast-clock edge where `sync_in` is sampled high, the output takes the level of `start_hi` (1 = high, 0 = low) and stays there while `sync_in` remains high.
- R3: Count edges from 0, starting with the first edge where `sync_in` is sampled low. The output keeps the starting level through edges 0 to `phase_ofs`−1 and makes its first transition at edge `phase_ofs` (0 to 15).
- R4: With a low starting level, the first transition goes high. The output then repeats high for `hi_len+1` edges and low for `lo_len+1` edges.
- R5: With a high starting level, the first transition goes low. The output then repeats low for `lo_len+1` edges and high for `hi_len+1` edges.
- R6: Changes to `hi_len`, `lo_len`, `start_hi` and `bypass` while `sync_in` is low do not alter the running output. They take effect at the next pulse.
- R7: If `bypass` was 1 at the last pulse, the output equals the fast clock (divide by 1), whatever `phase_ofs` and `start_hi` hold.
- R8: Several instances released by the same pulse with offsets a and b have their first rising edges exactly b−a fast-clock edges apart.
- R9: For ratio N, an offset of N gives the same output as an offset of 0 from edge N on.
- R10: While `rst` is high, the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_in | input | 1 | Realignment pulse, active high |
| hi_len | input | 4 | High segment length minus one |
| lo_len | input | 4 | Low segment length minus one |
| phase_ofs | input | 4 | Edges to wait after the pulse |
| start_hi | input | 1 | Starting level after the pulse |
| bypass | input | 1 | Divide-by-one pass-through |
| clk_out | output | 1 | Divided clock |

## Verification
The assertions assume that configuration is stable whenever it is sampled with `sync_in` high. They also assume that `sync_in` and the configuration change only away from the active edge. The bench meets both assumptions by driving every input on the falling edge.

The assertions check the registered divider level, not `clk_out`, so their timing rules hold in bypass too. They take the level as toggling only at the phase-wait expiry or at a segment boundary. The stimulus covers the shortest and longest segments, the largest offset, and offsets equal to the ratio.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  localparam int CNT_W = 4;
  localparam int PH_W  = 4;

  typedef struct packed {
    logic [CNT_W-1:0] hi_m1;
    logic [CNT_W-1:0] lo_m1;
    logic [PH_W-1:0]  phase;
    logic             start_hi;
    logic             bypass;
  } div_cfg_t;

  // Segment length (minus one) for the level the output is about to enter
  function automatic logic [CNT_W-1:0] seg_reload(input logic next_lvl, input div_cfg_t c);
    return next_lvl ? c.hi_m1 : c.lo_m1;
  endfunction

  function automatic div_cfg_t cfg_reset();
    div_cfg_t c;
    c.hi_m1    = '0;
    c.lo_m1    = '0;
    c.phase    = '0;
    c.start_hi = 1'b0;
    c.bypass   = 1'b0;
    return c;
  endfunction
endpackage

// File: rtl/pcd_cfg_shadow.sv
module pcd_cfg_shadow
  import pcd_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     sync,
  input  div_cfg_t cfg_in,
  output div_cfg_t cfg_q
);
  always_ff @(posedge clk) begin
    if (rst)       cfg_q <= cfg_reset();
    else if (sync) cfg_q <= cfg_in;
  end
endmodule

// File: rtl/pcd_phase_wait.sv
module pcd_phase_wait
  import pcd_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            sync,
  input  logic [PH_W-1:0] phase_in,
  output logic            running,
  output logic            fire_first,
  output logic            wait_busy
);
  logic [PH_W-1:0] wait_cnt;
  logic            wait_zero;

  assign wait_zero  = (wait_cnt == '0);
  assign fire_first = !sync && !running && wait_zero;
  assign wait_busy  = !running && !wait_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_cnt <= '0;
      running  <= 1'b0;
    end else if (sync) begin
      wait_cnt <= phase_in;
      running  <= 1'b0;
    end else if (!running) begin
      if (wait_zero) running  <= 1'b1;
      else           wait_cnt <= wait_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/pcd_duty_gen.sv
module pcd_duty_gen
  import pcd_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     sync,
  input  logic     start_in,
  input  div_cfg_t cfg,
  input  logic     fire_first,
  input  logic     running,
  output logic     level_q,
  output logic     seg_zero
);
  logic [CNT_W-1:0] seg_cnt;

  assign seg_zero = (seg_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= 1'b0;
      seg_cnt <= '0;
    end else if (sync) begin
      level_q <= start_in;
      seg_cnt <= '0;
    end else if (fire_first) begin
      level_q <= ~level_q;
      seg_cnt <= seg_reload(~level_q, cfg);
    end else if (running) begin
      if (seg_zero) begin
        level_q <= ~level_q;
        seg_cnt <= seg_reload(~level_q, cfg);
      end else begin
        seg_cnt <= seg_cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/phase_clk_div.sv
module phase_clk_div
  import pcd_pkg::*;
#(
  parameter int LEN_W = CNT_W,
  parameter int OFS_W = PH_W
) (
  input  logic             clk_fast,
  input  logic             rst,
  input  logic             sync_in,
  input  logic [LEN_W-1:0] hi_len,
  input  logic [LEN_W-1:0] lo_len,
  input  logic [OFS_W-1:0] phase_ofs,
  input  logic             start_hi,
  input  logic             bypass,
  output logic             clk_out
);
  div_cfg_t cfg_in;
  div_cfg_t cfg_q;
  logic     running;
  logic     fire_first;
  logic     wait_busy;
  logic     level_q;
  logic     seg_zero;

  always_comb begin
    cfg_in.hi_m1    = hi_len;
    cfg_in.lo_m1    = lo_len;
    cfg_in.phase    = phase_ofs;
    cfg_in.start_hi = start_hi;
    cfg_in.bypass   = bypass;
  end

  pcd_cfg_shadow u_shadow (
    .clk(clk_fast), .rst(rst), .sync(sync_in), .cfg_in(cfg_in), .cfg_q(cfg_q)
  );

  pcd_phase_wait u_wait (
    .clk(clk_fast), .rst(rst), .sync(sync_in), .phase_in(phase_ofs),
    .running(running), .fire_first(fire_first), .wait_busy(wait_busy)
  );

  pcd_duty_gen u_duty (
    .clk(clk_fast), .rst(rst), .sync(sync_in), .start_in(start_hi), .cfg(cfg_q),
    .fire_first(fire_first), .running(running), .level_q(level_q), .seg_zero(seg_zero)
  );

  assign clk_out = cfg_q.bypass ? clk_fast : level_q;
endmodule

// File: rtl/pcd_checker.sv
module pcd_checker (
  input logic clk_fast,
  input logic rst,
  input logic sync_in,
  input logic start_hi,
  input logic level_q,
  input logic fire_first,
  input logic running,
  input logic wait_busy,
  input logic seg_zero
);
  p_sync_level_r2: assert property (@(posedge clk_fast) disable iff (rst)
    sync_in |=> (level_q == $past(start_hi)));

  p_wait_hold_r3: assert property (@(posedge clk_fast) disable iff (rst)
    (!sync_in && wait_busy) |=> $stable(level_q));

  p_first_edge_r3: assert property (@(posedge clk_fast) disable iff (rst)
    fire_first |=> (level_q != $past(level_q)));

  p_seg_toggle_r4: assert property (@(posedge clk_fast) disable iff (rst)
    (!sync_in && running && seg_zero) |=> (level_q != $past(level_q)));

  p_seg_hold_r4: assert property (@(posedge clk_fast) disable iff (rst)
    (!sync_in && running && !seg_zero) |=> $stable(level_q));
endmodule

bind phase_clk_div pcd_checker u_pcd_checker (
  .clk_fast(clk_fast), .rst(rst), .sync_in(sync_in), .start_hi(start_hi),
  .level_q(level_q), .fire_first(fire_first), .running(running),
  .wait_busy(wait_busy), .seg_zero(seg_zero)
);

// File: tb/phase_clk_div_bench.sv
module phase_clk_div_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sync_in = 1'b0;
  logic [3:0] hi_len = 4'd1, lo_len = 4'd1;
  logic [3:0] ph_a = 4'd0, ph_b = 4'd0, ph_c = 4'd0;
  logic       start_hi = 1'b0, bypass = 1'b0;
  logic       out_a, out_b, out_c;

  int checks = 0;
  int errors = 0;
  string cur_req = "R10";

  // reference model state
  int m_h = 1, m_l = 1, m_ph = 0, m_st = 0, m_byp = 0, m_e = 0, m_exp = 0;

  always #5 clk = ~clk;

  phase_clk_div u_phase_clk_div (.clk_fast(clk), .rst(rst), .sync_in(sync_in),
    .hi_len(hi_len), .lo_len(lo_len), .phase_ofs(ph_a), .start_hi(start_hi),
    .bypass(bypass), .clk_out(out_a));
  phase_clk_div u_b (.clk_fast(clk), .rst(rst), .sync_in(sync_in),
    .hi_len(hi_len), .lo_len(lo_len), .phase_ofs(ph_b), .start_hi(start_hi),
    .bypass(bypass), .clk_out(out_b));
  phase_clk_div u_c (.clk_fast(clk), .rst(rst), .sync_in(sync_in),
    .hi_len(hi_len), .lo_len(lo_len), .phase_ofs(ph_c), .start_hi(start_hi),
    .bypass(bypass), .clk_out(out_c));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  function automatic int ref_level(input int e);
    int p;
    if (e < m_ph) return m_st;
    p = (e - m_ph) % (m_h + m_l);
    if (m_st == 0) return (p < m_h) ? 1 : 0;
    return (p < m_l) ? 0 : 1;
  endfunction

  // model update at each rising edge, compared during the high phase
  always @(posedge clk) begin
    if (rst) begin
      m_h = 1; m_l = 1; m_ph = 0; m_st = 0; m_byp = 0; m_e = 0; m_exp = 0;
    end else if (sync_in) begin
      m_h = int'(hi_len) + 1; m_l = int'(lo_len) + 1; m_ph = int'(ph_a);
      m_st = int'(start_hi); m_byp = int'(bypass); m_e = 0; m_exp = m_st;
    end else begin
      m_exp = ref_level(m_e);
      m_e++;
    end
    #3;
    check(cur_req, int'(out_a), (m_byp != 0) ? 1 : m_exp);
  end

  always @(negedge clk) begin
    #3;
    check(cur_req, int'(out_a), (m_byp != 0) ? 0 : m_exp);
  end

  task automatic pulse(input int n);
    @(negedge clk); sync_in = 1'b1;
    repeat (n) @(negedge clk);
    sync_in = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int first_a, first_b, first_c;
    cur_req = "R10";
    repeat (3) @(negedge clk);
    check("R10", int'(out_a), 0);
    @(negedge clk); rst = 1'b0;

    // R2: start level follows start_hi while held in sync
    cur_req = "R2";
    @(negedge clk); sync_in = 1'b1; start_hi = 1'b1;
    @(negedge clk); check("R2", int'(out_a), 1);
    start_hi = 1'b0;
    @(negedge clk); check("R2", int'(out_a), 0);
    sync_in = 1'b0;

    // R1/R4: divide by 4, no offset
    cur_req = "R4"; hi_len = 4'd1; lo_len = 4'd1; ph_a = 4'd0; start_hi = 1'b0;
    pulse(1); run(24);

    // R1/R5/R3: 3 high / 4 low, offset 5, high start
    cur_req = "R5"; hi_len = 4'd2; lo_len = 4'd3; ph_a = 4'd5; start_hi = 1'b1;
    pulse(2); run(40);

    // R3: shortest segments, largest offset
    cur_req = "R3"; hi_len = 4'd0; lo_len = 4'd0; ph_a = 4'd15; start_hi = 1'b0;
    pulse(1); run(40);

    // R1: longest segments
    cur_req = "R1"; hi_len = 4'd15; lo_len = 4'd15; ph_a = 4'd3;
    pulse(1); run(80);

    // R6: changes while running are ignored
    cur_req = "R6"; hi_len = 4'd1; lo_len = 4'd2; ph_a = 4'd1;
    pulse(1); run(6);
    hi_len = 4'd7; lo_len = 4'd0; start_hi = 1'b1; bypass = 1'b1;
    run(30);
    bypass = 1'b0; start_hi = 1'b0;

    // R8: shared pulse, offsets 0/1/2, divide by 4
    cur_req = "R8"; hi_len = 4'd1; lo_len = 4'd1; ph_a = 4'd0; ph_b = 4'd1; ph_c = 4'd2;
    pulse(1);
    first_a = -1; first_b = -1; first_c = -1;
    for (int e = 0; e < 12; e++) begin
      @(posedge clk); #2;
      if (out_a && first_a < 0) first_a = e;
      if (out_b && first_b < 0) first_b = e;
      if (out_c && first_c < 0) first_c = e;
    end
    check("R8", first_b - first_a, 1);
    check("R8", first_c - first_a, 2);
    check("R8", first_a, 0);

    // R9: offset equal to the ratio matches offset 0 after N edges
    cur_req = "R9"; ph_a = 4'd0; ph_b = 4'd4;
    pulse(1);
    for (int e = 0; e < 20; e++) begin
      @(posedge clk); #2;
      if (e >= 4) check("R9", int'(out_b), int'(out_a));
    end

    // R7: bypass passes the clock, offset and start ignored
    cur_req = "R7"; bypass = 1'b1; ph_a = 4'd9; start_hi = 1'b1;
    pulse(1); run(12);
    bypass = 1'b0; start_hi = 1'b0; ph_a = 4'd2;
    cur_req = "R4";
    pulse(1); run(12);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule